// File: doc/BRIEF.md
# Floored Signed Divide-Modulo Unit

This unit divides a dividend A by a divisor B and returns a quotient and a remainder. When both operands are signed, it rounds the quotient toward minus infinity rather than toward zero. The remainder then satisfies A = Q·B + R and, when nonzero, carries the sign of the divisor. Parameters set whether each operand is signed, along with the dividend, divisor and quotient widths. When either operand is unsigned, the unit does ordinary truncating division.

A caller pulses `start` with the operands while the unit is idle. The unit captures the operands and builds an adjusted dividend. When the operand signs differ and A is nonzero, it subtracts B-plus-one (for negative B) or B-minus-one (otherwise) from A. A restoring shift-subtract core then divides the magnitudes, one quotient bit per clock. After the last step, one cycle applies the signs and corrects the remainder, and `done` pulses with the results. A zero divisor is reported on a flag instead of being trapped.

All internal arithmetic is one bit wider than the largest of the three widths, so the adjustment cannot overflow.

Top module: `floor_divmod`

## Requirements
- R1: After reset `busy`, `done` and `div_by_zero` are low and `quotient` and `remainder` are zero.
- R2: A `start` sampled high while `busy` is low is accepted at that edge, and `busy` is high from the next cycle. `done` is high for exactly one cycle, after the (W+1)th rising edge following the accepting edge, where W = max(AW, BW, QW) + 1. `busy` is low while `done` is high.
- R3: A `start` sampled while `busy` is high is ignored. The running operation's results are unaffected and no extra `done` pulse appears.
- R4: With both operands signed and B nonzero, `quotient` equals floor(A/B), taken modulo 2^QW.
- R5: With both operands signed and B nonzero, `remainder` equals A − floor(A/B)·B, taken modulo 2^AW. A nonzero remainder has the sign of B.
- R6: With both operands signed, when A is zero or A and B have the same sign, the results equal truncating division. Exact divisions give a zero remainder.
- R7: If either operand is unsigned, each operand is read as a value according to its own signedness. `quotient` is then that value quotient truncated toward zero, and `remainder` is the truncated remainder with the dividend's sign.
- R8: When B is zero, `div_by_zero` is high together with `done`, `quotient` is all ones and `remainder` equals A. Otherwise `div_by_zero` is low.
- R9: The most negative A divided by −1 gives the most negative quotient (wrapped to QW bits) with a zero remainder and `div_by_zero` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only while idle |
| a_in | input | AW | Dividend |
| b_in | input | BW | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | QW | Floored (or truncated) quotient |
| remainder | output | AW | Matching remainder |
| div_by_zero | output | 1 | Divisor was zero |

## Verification
The bench builds two copies with 8-bit widths, so W is 9 and the latency is ten edges. The first copy has both operands signed, which brings all four sign pairings into range. It also covers the extreme pairs −128/−1, −128/127 and 127/−128, together with zero dividends and exact divisions. The second copy takes A as signed and B as unsigned, so divisors above 127 exercise the truncating fallback on the same stimulus.

// File: rtl/floor_divmod.sv
module floor_divmod #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int QW = 8,
  parameter bit A_SIGNED = 1'b1,
  parameter bit B_SIGNED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic [AW-1:0] remainder,
  output logic          div_by_zero
);
  localparam int  M0    = (AW > BW) ? AW : BW;
  localparam int  M     = (M0 > QW) ? M0 : QW;
  localparam int  W     = M + 1;
  localparam int  CW    = $clog2(W + 1);
  localparam bit  FLOOR = A_SIGNED && B_SIGNED;

  // operands widened by their own signedness
  logic [W-1:0] a_x, b_x, b_pm, n_x, n_mag, b_mag;
  assign a_x = {{(W-AW){A_SIGNED ? a_in[AW-1] : 1'b0}}, a_in};
  assign b_x = {{(W-BW){B_SIGNED ? b_in[BW-1] : 1'b0}}, b_in};

  logic adj_now;
  assign adj_now = FLOOR && (a_x[W-1] ^ b_x[W-1]) && (a_in != '0);
  assign b_pm    = b_x[W-1] ? b_x + 1'b1 : b_x - 1'b1;
  assign n_x     = adj_now ? a_x - b_pm : a_x;
  assign n_mag   = n_x[W-1] ? ~n_x + 1'b1 : n_x;
  assign b_mag   = b_x[W-1] ? ~b_x + 1'b1 : b_x;

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem_r, quo_r, dvs_r, bsx_r;
  logic [AW-1:0] a_r;
  logic          negq_r, negr_r, adj_r;

  logic [W:0] shifted, trial;
  assign shifted = {rem_r, quo_r[W-1]};
  assign trial   = shifted - {1'b0, dvs_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      cnt         <= '0;
      rem_r       <= '0;
      quo_r       <= '0;
      dvs_r       <= '0;
      bsx_r       <= '0;
      a_r         <= '0;
      negq_r      <= 1'b0;
      negr_r      <= 1'b0;
      adj_r       <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= CW'(W);
          rem_r  <= '0;
          quo_r  <= n_mag;
          dvs_r  <= b_mag;
          bsx_r  <= b_x;
          a_r    <= a_in;
          negq_r <= n_x[W-1] ^ b_x[W-1];
          negr_r <= n_x[W-1];
          adj_r  <= adj_now;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (!trial[W]) begin
          rem_r <= trial[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b1};
        end else begin
          rem_r <= shifted[W-1:0];
          quo_r <= {quo_r[W-2:0], 1'b0};
        end
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (dvs_r == '0) begin
          div_by_zero <= 1'b1;
          quotient    <= '1;
          remainder   <= a_r;
        end else begin
          div_by_zero <= 1'b0;
          quotient    <= QW'(negq_r ? ~quo_r + 1'b1 : quo_r);
          // undo the +/-1 of the dividend adjustment and add the divisor
          remainder   <= AW'((negr_r ? ~rem_r + 1'b1 : rem_r)
                             + (adj_r ? bsx_r + (bsx_r[W-1] ? W'(1) : {W{1'b1}}) : '0));
        end
      end
    end
  end

  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dvs_r) && $stable(bsx_r) && $stable(a_r));
  a_r8_zero_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_by_zero |-> (&quotient) && (remainder == a_r));
endmodule

// File: tb/floor_divmod_tb.sv
`timescale 1ns/1ps
module floor_divmod_tb;
  localparam int LAT = 10; // W = 9, done after W+1 edges

  typedef struct {
    logic [7:0] q;
    logic [7:0] r;
    logic       z;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  always #2.5 clk = ~clk;

  logic busy, done, dz;
  logic [7:0] quo, rem;
  logic busy_m, done_m, dz_m;
  logic [7:0] quo_m, rem_m;

  floor_divmod #(.AW(8), .BW(8), .QW(8), .A_SIGNED(1'b1), .B_SIGNED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .quotient(quo), .remainder(rem), .div_by_zero(dz));

  floor_divmod #(.AW(8), .BW(8), .QW(8), .A_SIGNED(1'b1), .B_SIGNED(1'b0)) u_dut_mix (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy_m), .done(done_m), .quotient(quo_m), .remainder(rem_m), .div_by_zero(dz_m));

  int checks = 0, failures = 0;
  exp_t q_fl[$];
  exp_t q_mx[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t ref_floor(input logic [7:0] a8, input logic [7:0] b8, input string tag);
    exp_t e;
    int a, b, qi, ri;
    a = int'($signed(a8));
    b = int'($signed(b8));
    e.tag = tag;
    if (b == 0) begin
      e.q = 8'hFF; e.r = a8; e.z = 1'b1;
    end else begin
      qi = a / b;
      if ((a % b) != 0 && ((a < 0) != (b < 0))) qi = qi - 1;
      ri = a - qi * b;
      e.q = qi[7:0]; e.r = ri[7:0]; e.z = 1'b0;
    end
    return e;
  endfunction

  function automatic exp_t ref_trunc(input logic [7:0] a8, input logic [7:0] b8, input string tag);
    exp_t e;
    int a, b, qi, ri;
    a = int'($signed(a8));
    b = int'({24'd0, b8});
    e.tag = tag;
    if (b == 0) begin
      e.q = 8'hFF; e.r = a8; e.z = 1'b1;
    end else begin
      qi = a / b;
      ri = a % b;
      e.q = qi[7:0]; e.r = ri[7:0]; e.z = 1'b0;
    end
    return e;
  endfunction

  // driver: pushes expectations, issues the request, checks latency (R2)
  task automatic go(input logic [7:0] a, input logic [7:0] b, input string tag,
                    input bit poke_busy = 1'b0);
    int n;
    q_fl.push_back(ref_floor(a, b, tag));
    q_mx.push_back(ref_trunc(a, b, "R7"));
    @(negedge clk);
    start = 1'b1; a_in = a; b_in = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    n = 0;
    while (n < 100) begin
      if (poke_busy && n == 3) begin
        start = 1'b1; a_in = 8'd99; b_in = 8'd7; // R3: must be ignored
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
    check(n == LAT, "R2", "done latency", n, LAT);
    check(busy == 1'b0, "R2", "busy with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R2", "done width", done, 0);
  endtask

  // monitors: pop and compare
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_fl.size() == 0) check(1'b0, "R3", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q_fl.pop_front();
        check(quo == e.q, e.tag, "quotient", int'($signed(quo)), int'($signed(e.q)));
        check(rem == e.r, e.tag, "remainder", int'($signed(rem)), int'($signed(e.r)));
        check(dz == e.z, "R8", "div_by_zero", dz, e.z);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && done_m) begin
      if (q_mx.size() == 0) check(1'b0, "R3", "unexpected done (mixed)", 1, 0);
      else begin
        exp_t e;
        e = q_mx.pop_front();
        check(quo_m == e.q, e.tag, "mixed quotient", int'($signed(quo_m)), int'($signed(e.q)));
        check(rem_m == e.r, e.tag, "mixed remainder", int'($signed(rem_m)), int'($signed(e.r)));
        check(dz_m == e.z, "R8", "mixed div_by_zero", dz_m, e.z);
      end
    end
  end

  bit finished = 1'b0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && dz == 0, "R1", "flags after reset", {busy, done, dz}, 0);
    check(quo == 0 && rem == 0, "R1", "results after reset", {quo, rem}, 0);

    go(8'd7,    8'd2,   "R6");
    go(8'd7,    -8'd2,  "R4");
    go(-8'd7,   8'd2,   "R5");
    go(-8'd7,   -8'd2,  "R6");
    go(8'd0,    -8'd5,  "R6");
    go(8'd0,    8'd5,   "R6");
    go(8'd6,    -8'd3,  "R4");
    go(-8'd6,   8'd2,   "R5");
    go(8'h80,   8'hFF,  "R9");
    go(8'h80,   8'd1,   "R4");
    go(8'd127,  8'h80,  "R5");
    go(8'h80,   8'd127, "R4");
    go(8'd1,    8'h80,  "R5");
    go(-8'd1,   8'd127, "R5");
    go(8'd5,    8'd0,   "R8");
    go(-8'd9,   8'd0,   "R8");
    go(-8'd13,  8'd200, "R7");
    go(8'd100,  8'd255, "R7");
    go(-8'd20,  8'd3,   "R4", 1'b1);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      a = 8'(i * 37 - 100);
      b = 8'(i * 13 - 90);
      go(a, b, (i % 2) ? "R4" : "R5");
    end
    repeat (4) @(negedge clk);
    check(q_fl.size() == 0, "R3", "pending results", q_fl.size(), 0);
    check(q_mx.size() == 0, "R7", "pending mixed results", q_mx.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule